// File: doc/BRIEF.md
# Run-time configurable gate grid

This block is a small grid of programmable logic elements laid out in columns and rows, in the manner of Cartesian genetic programming. A packed gene word sets each element's two operand sources and its logic function, and a separate group of output genes picks which nodes drive the three outputs. A search engine elsewhere on the chip proposes a candidate gene word, loads it with a single strobe, and then sweeps the four primary inputs to score the circuit that results.

The default grid has four columns of four elements. An element may read a primary input or any element in a column to its left. Every operand and output choice is made by a multiplexer. The grid cannot form a combinational loop whatever gene word it holds, because a source code that points at the element's own column or at a later column is replaced by a primary input. Elements that no output depends on have no effect.

The gene word is held in a register. The logic evaluation is purely combinational from that register and the primary inputs.

Top module: `cgp_grid`

## Requirements
- R1: After synchronous reset, and until the first load, every output equals primary input a0 (`pi[0]`).
- R2: When `load` is high at a rising clock edge, `chrom_in` and `ogene_in` are captured. When `load` is low, a changed `chrom_in` or `ogene_in` has no effect on the outputs.
- R3: Element k (k = column*4 + row, so numbering is column-major) takes its configuration from `chrom_in[11k+10:11k]`. That field is packed as {first source[3:0], second source[3:0], function[2:0]}.
- R4: Source codes 0 to 3 select a0, a1, b0, b1, which are `pi[0]` to `pi[3]`. Source codes 4 to 15 select elements 0 to 11, provided the selected element lies in an earlier column.
- R5: A source code that names an element in the same column or in a later column reads primary input (code mod 4) instead.
- R6: Function codes: 0 is XOR of the two operands, 1 is AND, 2 is OR, 3 is NOT of the first operand, and 4 passes the first operand through.
- R7: Function codes 5, 6 and 7 pass the first operand through, the same as code 4.
- R8: Output j is chosen by `ogene_in[5j+4:5j]`. Values 0 to 3 select a primary input, and values 4 to 19 select elements 0 to 15.
- R9: An output gene with a value above 19 drives its output to 0.
- R10: The outputs follow a change on `pi` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the stored genes |
| load | input | 1 | Capture strobe for the gene words |
| chrom_in | input | 176 | Element gene word, 11 bits per element |
| ogene_in | input | 15 | Three 5-bit output genes |
| pi | input | 4 | Primary inputs {b1, b0, a1, a0} |
| po | output | 3 | Grid outputs |

## Verification
The bench builds the grid with its default parameters: four columns, four rows, four primary inputs and three outputs. At this size every source code and output gene value is reachable. This includes codes that point forward or into the element's own column, and output genes above the last node. A hand-wired two-bit adder is checked against the arithmetic sum for all sixteen input patterns. Randomly drawn gene words, loaded with a random strobe, are then compared each cycle with a behavioural model.

// File: rtl/cgp_pkg.sv
`timescale 1ns/1ps
package cgp_pkg;
  localparam int FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_XOR  = 3'd0,
    FN_AND  = 3'd1,
    FN_OR   = 3'd2,
    FN_NOT  = 3'd3,
    FN_PASS = 3'd4
  } fn_e;
endpackage

// File: rtl/cgp_cfg_reg.sv
`timescale 1ns/1ps
module cgp_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/cgp_pe.sv
`timescale 1ns/1ps
module cgp_pe
  import cgp_pkg::*;
#(
  parameter int N_PI  = 4,
  parameter int N_SRC = 4,
  parameter int SEL_W = 4,
  localparam int GENE_W = 2*SEL_W + FN_W
) (
  input  logic [N_SRC-1:0]  src,
  input  logic [GENE_W-1:0] gene,
  output logic              y
);
  logic [SEL_W-1:0] sel_a, sel_b;
  logic [FN_W-1:0]  fn_bits;
  logic             op_a, op_b;

  assign sel_a   = gene[GENE_W-1 -: SEL_W];
  assign sel_b   = gene[FN_W+SEL_W-1 -: SEL_W];
  assign fn_bits = gene[FN_W-1:0];

  // Codes that do not name an earlier node fall back to a primary input
  function automatic logic pick(input logic [SEL_W-1:0] code,
                                input logic [N_SRC-1:0] s);
    int eff;
    logic v;
    eff = int'(code) % N_PI;
    if (int'(code) < N_SRC) eff = int'(code);
    v = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (i == eff) v = s[i];
    return v;
  endfunction

  always_comb begin
    op_a = pick(sel_a, src);
    op_b = pick(sel_b, src);
    case (fn_e'(fn_bits))
      FN_XOR:  y = op_a ^ op_b;
      FN_AND:  y = op_a & op_b;
      FN_OR:   y = op_a | op_b;
      FN_NOT:  y = ~op_a;
      default: y = op_a;
    endcase
  end
endmodule

// File: rtl/cgp_osel.sv
`timescale 1ns/1ps
module cgp_osel #(
  parameter int N_NODE = 20,
  parameter int N_PO   = 3,
  parameter int OG_W   = 5
) (
  input  logic [N_NODE-1:0]    nodes,
  input  logic [N_PO*OG_W-1:0] genes,
  output logic [N_PO-1:0]      po
);
  for (genvar j = 0; j < N_PO; j++) begin : g_out
    logic [OG_W-1:0] g;
    assign g = genes[j*OG_W +: OG_W];
    always_comb begin
      po[j] = 1'b0;
      for (int n = 0; n < N_NODE; n++)
        if (int'(g) == n) po[j] = nodes[n];
    end
  end
endmodule

// File: rtl/cgp_grid.sv
`timescale 1ns/1ps
module cgp_grid
  import cgp_pkg::*;
#(
  parameter int N_COLS = 4,
  parameter int N_ROWS = 4,
  parameter int N_PI   = 4,
  parameter int N_PO   = 3,
  localparam int N_ELEM  = N_COLS * N_ROWS,
  localparam int N_NODE  = N_PI + N_ELEM,
  localparam int SEL_W   = $clog2(N_PI + (N_COLS-1)*N_ROWS),
  localparam int ELEM_W  = 2*SEL_W + FN_W,
  localparam int CHROM_W = N_ELEM * ELEM_W,
  localparam int OG_W    = $clog2(N_NODE),
  localparam int OGENE_W = N_PO * OG_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CHROM_W-1:0] chrom_in,
  input  logic [OGENE_W-1:0] ogene_in,
  input  logic [N_PI-1:0]    pi,
  output logic [N_PO-1:0]    po
);
  logic [CHROM_W-1:0] chrom_q;
  logic [OGENE_W-1:0] ogene_q;
  logic [N_NODE-1:0]  all_nodes;

  cgp_cfg_reg #(.W(CHROM_W + OGENE_W)) u_cfg (
    .clk (clk),
    .rst (rst),
    .ld  (load),
    .d   ({ogene_in, chrom_in}),
    .q   ({ogene_q, chrom_q})
  );

  assign all_nodes[N_PI-1:0] = pi;

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    localparam int N_SRC = N_PI + c*N_ROWS;
    logic [N_SRC-1:0]  src;
    logic [N_ROWS-1:0] c_out;

    assign src[N_PI-1:0] = pi;
    for (genvar p = 0; p < c; p++) begin : g_prev
      assign src[N_PI + p*N_ROWS +: N_ROWS] = g_col[p].c_out;
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      localparam int K = c*N_ROWS + r;
      cgp_pe #(.N_PI(N_PI), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_pe (
        .src  (src),
        .gene (chrom_q[K*ELEM_W +: ELEM_W]),
        .y    (c_out[r])
      );
    end

    assign all_nodes[N_PI + c*N_ROWS +: N_ROWS] = c_out;
  end

  cgp_osel #(.N_NODE(N_NODE), .N_PO(N_PO), .OG_W(OG_W)) u_osel (
    .nodes (all_nodes),
    .genes (ogene_q),
    .po    (po)
  );
endmodule

// File: rtl/cgp_grid_chk.sv
`timescale 1ns/1ps
module cgp_grid_chk #(
  parameter int N_PI   = 4,
  parameter int N_PO   = 3,
  parameter int N_NODE = 20,
  parameter int OG_W   = 5,
  localparam int PI_IW = $clog2(N_PI)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 load,
  input logic [N_PI-1:0]      pi,
  input logic [N_PO-1:0]      po,
  input logic [N_PO*OG_W-1:0] ogene_q
);
  // R1: right after reset every output mirrors a0
  assert_reset_a0_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> po == {N_PO{pi[0]}});

  // R2: no strobe and quiet inputs keep the outputs still
  assert_hold_cfg_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && $stable(pi)) |-> $stable(po));

  for (genvar j = 0; j < N_PO; j++) begin : g_og
    // R8: gene below N_PI routes a primary input straight out
    assert_pi_route_R8: assert property (@(posedge clk) disable iff (rst)
      (int'(ogene_q[j*OG_W +: OG_W]) < N_PI)
        |-> po[j] == pi[ogene_q[j*OG_W +: PI_IW]]);
    // R9: gene beyond the last node forces zero
    assert_force_zero_R9: assert property (@(posedge clk) disable iff (rst)
      (int'(ogene_q[j*OG_W +: OG_W]) >= N_NODE) |-> po[j] == 1'b0);
  end
endmodule

bind cgp_grid cgp_grid_chk #(
  .N_PI(N_PI), .N_PO(N_PO), .N_NODE(N_NODE), .OG_W(OG_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load    (load),
  .pi      (pi),
  .po      (po),
  .ogene_q (ogene_q)
);

// File: tb/cgp_grid_tb.sv
`timescale 1ns/1ps
module cgp_grid_tb;
  localparam int CW = 176;
  localparam int OW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic [CW-1:0] chrom = '0;
  logic [OW-1:0] og = '0;
  logic [3:0]    pi = '0;
  logic [2:0]    po;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  logic [CW-1:0] m_ch;
  logic [OW-1:0] m_og;

  always #2.5 clk = ~clk;

  cgp_grid u_dut (
    .clk(clk), .rst(rst), .load(load),
    .chrom_in(chrom), .ogene_in(og), .pi(pi), .po(po)
  );

  // behavioural reference: stored genes
  always @(posedge clk) begin
    if (rst) begin
      m_ch <= '0;
      m_og <= '0;
    end else if (load) begin
      m_ch <= chrom;
      m_og <= og;
    end
  end

  function automatic logic [2:0] ref_eval(logic [CW-1:0] ch, logic [OW-1:0] g,
                                          logic [3:0] p);
    logic v [20];
    logic [2:0] r;
    for (int i = 0; i < 4; i++) v[i] = p[i];
    for (int k = 0; k < 16; k++) begin
      int col, s1, s2, f;
      logic x, y;
      col = k / 4;
      s1  = int'(ch[11*k+7 +: 4]);
      s2  = int'(ch[11*k+3 +: 4]);
      f   = int'(ch[11*k +: 3]);
      x = (s1 < 4) ? p[s1] : ((s1 - 4 < col*4) ? v[s1] : p[s1 % 4]);
      y = (s2 < 4) ? p[s2] : ((s2 - 4 < col*4) ? v[s2] : p[s2 % 4]);
      case (f)
        0: v[4+k] = x ^ y;
        1: v[4+k] = x & y;
        2: v[4+k] = x | y;
        3: v[4+k] = ~x;
        default: v[4+k] = x;
      endcase
    end
    for (int j = 0; j < 3; j++) begin
      int gv;
      gv = int'(g[5*j +: 5]);
      r[j] = (gv < 20) ? v[gv] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] set_pe(logic [CW-1:0] ch, int k, int s1, int s2, int f);
    logic [CW-1:0] c;
    c = ch;
    c[11*k +: 11] = {s1[3:0], s2[3:0], f[2:0]};
    return c;
  endfunction

  function automatic logic [OW-1:0] mk_og(int g0, int g1, int g2);
    return {g2[4:0], g1[4:0], g0[4:0]};
  endfunction

  task automatic check(string tag, logic [2:0] exp);
    n_chk++;
    if (po !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, po, exp);
    end
  endtask

  // every-clock comparison with the model (R3 R4 R5 R6 R7 R8 R9)
  always @(negedge clk) begin
    if (!rst && !done) check("R3 R6 model compare", ref_eval(m_ch, m_og, pi));
  end

  task automatic load_cfg(logic [CW-1:0] ch, logic [OW-1:0] g);
    @(negedge clk); #1;
    chrom = ch; og = g; load = 1'b1;
    @(negedge clk); #1;
    load = 1'b0;
  endtask

  task automatic set_pi(logic [3:0] p);
    @(negedge clk); #1;
    pi = p;
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [CW-1:0] c;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;

    // R1: reset state, outputs mirror a0
    set_pi(4'b0101); check("R1 reset a0=1", 3'b111);
    set_pi(4'b1110); check("R1 reset a0=0", 3'b000);

    // two-bit adder: a={a1,a0}, b={b1,b0}
    c = '0;
    c = set_pe(c, 0, 0, 2, 0);  // s0
    c = set_pe(c, 1, 0, 2, 1);  // carry0
    c = set_pe(c, 2, 1, 3, 0);  // half sum bit1
    c = set_pe(c, 3, 1, 3, 1);  // gen bit1
    c = set_pe(c, 4, 6, 5, 0);  // s1
    c = set_pe(c, 5, 6, 5, 1);  // propagate
    c = set_pe(c, 8, 7, 9, 2);  // carry out
    load_cfg(c, mk_og(4, 8, 12));
    for (int i = 0; i < 16; i++) begin
      logic [2:0] sum;
      sum = 3'({pi[1], pi[0]}) ;
      set_pi(4'(i));
      sum = 3'(i % 4) + 3'(i / 4);
      // R3 R4 R6 R8 R10: adder built from packed genes
      check("R4 R8 adder sum", sum);
    end

    // R2: change genes with load low, outputs keep adder behaviour
    @(negedge clk); #1;
    chrom = '0; og = mk_og(20, 20, 20);
    repeat (3) @(negedge clk);
    #1; pi = 4'b0111; #1;
    check("R2 load low ignored", 3'b100);

    // R5: forward and same-column references fall back to pi[code%4]
    c = '0;
    c = set_pe(c, 0, 9, 0, 4);    // col0 names elem5 -> a1
    c = set_pe(c, 4, 9, 0, 3);    // col1 names elem5 (same col) -> ~a1
    c = set_pe(c, 12, 15, 0, 4);  // col3 names elem11 (earlier) valid
    c = set_pe(c, 11, 0, 2, 1);   // elem11 = a0 & b0
    load_cfg(c, mk_og(4, 8, 16));
    set_pi(4'b0010); check("R5 fallback a1=1", {1'b0, 1'b0, 1'b1});
    set_pi(4'b0101); check("R5 fallback a1=0 elem11", {1'b1, 1'b1, 1'b0});

    // R6 R7: NOT and codes 5..7 act on first operand b1
    c = '0;
    c = set_pe(c, 0, 3, 0, 3);
    c = set_pe(c, 1, 3, 0, 5);
    c = set_pe(c, 2, 3, 0, 6);
    c = set_pe(c, 3, 3, 0, 7);
    c = set_pe(c, 4, 5, 6, 1);    // elem1 & elem2
    load_cfg(c, mk_og(4, 5, 7));
    set_pi(4'b1000); check("R6 R7 b1=1", 3'b110);
    set_pi(4'b0001); check("R6 R7 b1=0", 3'b001);
    load_cfg(c, mk_og(8, 3, 6));
    set_pi(4'b1001); check("R6 AND of wires", 3'b111);

    // R9: genes above 19 force zero; 19 picks elem15
    c = set_pe('0, 15, 0, 0, 3);  // elem15 = ~a0
    load_cfg(c, mk_og(20, 31, 19));
    set_pi(4'b0000); check("R9 out zero, elem15", 3'b100);
    set_pi(4'b1111); check("R9 out zero, a0=1", 3'b000);

    // R10: combinational response inside a cycle
    load_cfg('0, mk_og(0, 1, 2));
    @(negedge clk); #1; pi = 4'b0101;
    #0.5 check("R10 same cycle", 3'b101);
    #0.5 pi = 4'b1010;
    #0.5 check("R10 same cycle again", 3'b010);

    // random gene words, random strobe, model compare each clock
    for (int it = 0; it < 400; it++) begin
      @(negedge clk); #1;
      for (int w = 0; w < CW; w += 32) chrom[w +: 16] = 16'($urandom);
      for (int w = 16; w < CW; w += 32) chrom[w +: 16] = 16'($urandom);
      og   = OW'($urandom);
      load = 1'($urandom);
      pi   = 4'($urandom);
    end
    @(negedge clk); #1; load = 1'b0;

    // R1: reset again mid-run
    rst = 1'b1;
    @(negedge clk); #1; rst = 1'b0; pi = 4'b0001; #1;
    check("R1 reset after use", 3'b111);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule